// File: doc/BRIEF.md
# Strap-Sampling Status LED Driver

This block owns five bidirectional pads that serve two purposes. While the chip is held in power-on or hardware reset, the pads are inputs. External pull resistors set their levels, and those levels are the configuration straps. On the first clock edge after reset ends, the block latches the five levels as the device's 5-bit PHY address. On that same edge it turns all five pads into outputs that drive status LEDs.

Each pad's LED polarity follows its own strap. A pad strapped low drives high when its status is active, and a pad strapped high drives low. An idle pad drives its strap level, so the LED stays dark. Activity, transmit and receive events are short pulses, so they are stretched to a minimum on-time that a person can see. Link integrity and collision are levels and pass straight through.

A software reset clears the stretched indications and leaves the pad direction and the latched address alone. An address of zero asserts an MII disable output so that the MII can be tri-stated.

Top module: `strap_led_driver`

## Requirements
- R1: While `por_n` or `hw_rst_n` is low at a clock edge, after that edge `pin_oe` is 5'b00000, `pin_out` is 5'b00000 and `phy_addr` is 5'b00000.
- R2: On the first rising clock edge at which both resets are high, `phy_addr` takes `pin_in` (bit i from pad i) and `pin_oe` becomes 5'b11111.
- R3: After capture, `phy_addr` and `pin_oe` keep their values whatever `pin_in` does, until a new power-on or hardware reset.
- R4: `sw_rst` changes neither `pin_oe` nor `phy_addr`.
- R5: With every status input low and no stretch pending, `pin_out[i]` equals `phy_addr[i]`, which keeps the LED dark.
- R6: Pad bit 1 shows `st_col` and pad bit 2 shows `st_link` without delay or stretching: `pin_out[k]` is `phy_addr[k]` XOR the status level.
- R7: A high `st_act` (pad 0), `st_txd` (pad 3) or `st_rxd` (pad 4) at a clock edge inverts that pad relative to its strap for exactly STRETCH cycles after the edge. A new pulse restarts the count.
- R8: `sw_rst` high at an edge clears every pending stretch, and it takes priority over a pulse at the same edge. After that edge, pads 0, 3 and 4 return to their strap levels.
- R9: `mii_disable` is high exactly when `phy_addr` is 5'b00000, and that includes the period of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| hw_rst_n | input | 1 | Hardware reset, active low |
| sw_rst | input | 1 | Software reset, active high, synchronous |
| pin_in | input | 5 | Pad input levels (strap sense) |
| st_act | input | 1 | Link activity event pulse |
| st_col | input | 1 | Collision level |
| st_link | input | 1 | Link integrity level |
| st_txd | input | 1 | Transmit data event pulse |
| st_rxd | input | 1 | Receive data event pulse |
| pin_out | output | 5 | Pad output levels |
| pin_oe | output | 5 | Pad output enables |
| phy_addr | output | 5 | Latched strap address |
| mii_disable | output | 1 | High when the latched address is zero |

## Verification
The assertions assume that both resets and all status and strap inputs change only between clock edges, and that the pad levels are settled on the edge where reset is released. The capture check relies on this, because it compares against the pad value sampled at that edge. The bench drives every input one time unit after a rising edge and holds it across the next edge, so none of these assumptions is broken. Random reset pulses, software resets and status patterns then run through the same reference model as the directed corner cases.

// File: rtl/strap_led_driver.sv
module strap_led_driver #(
  parameter int STRETCH = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       hw_rst_n,
  input  logic       sw_rst,
  input  logic [4:0] pin_in,
  input  logic       st_act,
  input  logic       st_col,
  input  logic       st_link,
  input  logic       st_txd,
  input  logic       st_rxd,
  output logic [4:0] pin_out,
  output logic [4:0] pin_oe,
  output logic [4:0] phy_addr,
  output logic       mii_disable
);
  localparam int NPIN = 5;
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [NPIN-1:0] PULSE_MASK = 5'b11001;

  logic            rst_n;
  logic            oe_q;
  logic [NPIN-1:0] strap_q;
  logic [NPIN-1:0] status;
  logic [NPIN-1:0] ind;

  assign rst_n  = por_n & hw_rst_n;
  assign status = {st_rxd, st_txd, st_link, st_col, st_act};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q    <= 1'b0;
      strap_q <= '0;
    end else if (!oe_q) begin
      oe_q    <= 1'b1;
      strap_q <= pin_in;
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_ch
    if (PULSE_MASK[i]) begin : g_stretch
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n || sw_rst)
          cnt <= '0;
        else if (status[i])
          cnt <= CW'(STRETCH);
        else if (cnt != '0)
          cnt <= cnt - 1'b1;
      end
      assign ind[i] = |cnt;
    end else begin : g_level
      assign ind[i] = status[i];
    end
  end

  assign pin_oe      = {NPIN{oe_q}};
  assign pin_out     = oe_q ? (strap_q ^ ind) : '0;
  assign phy_addr    = strap_q;
  assign mii_disable = (strap_q == '0);
endmodule

module strap_led_checker (
  input logic       clk,
  input logic       por_n,
  input logic       hw_rst_n,
  input logic       sw_rst,
  input logic [4:0] pin_in,
  input logic       st_act,
  input logic       st_txd,
  input logic       st_rxd,
  input logic [4:0] pin_out,
  input logic [4:0] pin_oe,
  input logic [4:0] phy_addr,
  input logic       mii_disable
);
  logic rst_n;
  assign rst_n = por_n & hw_rst_n;

  p_oe_off_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == 5'b0 && phy_addr == 5'b0));

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |=> (pin_oe == 5'b11111 && phy_addr == $past(pin_in)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[0] |=> (pin_oe == 5'b11111 && $stable(phy_addr)));

  p_swrst_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rst && pin_oe[0]) |=> (pin_oe == 5'b11111 && $stable(phy_addr)));

  p_act_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe[0] && st_act && !sw_rst) |=> (pin_out[0] != phy_addr[0]));

  p_swrst_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe[0] && sw_rst) |=> (pin_out[0] == phy_addr[0] &&
                              pin_out[3] == phy_addr[3] &&
                              pin_out[4] == phy_addr[4]));

  p_mii_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[0] |=> $stable(mii_disable));

  p_mii_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mii_disable |-> (phy_addr == 5'b0));
endmodule

bind strap_led_driver strap_led_checker u_chk (
  .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst),
  .pin_in(pin_in), .st_act(st_act), .st_txd(st_txd), .st_rxd(st_rxd),
  .pin_out(pin_out), .pin_oe(pin_oe), .phy_addr(phy_addr),
  .mii_disable(mii_disable)
);

// File: tb/tb_strap_led_driver.sv
module tb_strap_led_driver;
  localparam int STRETCH = 4;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, hw_rst_n = 1'b0, sw_rst = 1'b0;
  logic [4:0] pin_in = 5'b0;
  logic       st_act = 0, st_col = 0, st_link = 0, st_txd = 0, st_rxd = 0;
  logic [4:0] pin_out, pin_oe, phy_addr;
  logic       mii_disable;

  int n_tests = 0, n_fail = 0;

  logic       m_oe = 1'b0;
  logic [4:0] m_strap = 5'b0;
  int         m_cnt [5] = '{0, 0, 0, 0, 0};

  always #2 clk = ~clk;

  strap_led_driver #(.STRETCH(STRETCH)) dut (
    .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst),
    .pin_in(pin_in), .st_act(st_act), .st_col(st_col), .st_link(st_link),
    .st_txd(st_txd), .st_rxd(st_rxd), .pin_out(pin_out), .pin_oe(pin_oe),
    .phy_addr(phy_addr), .mii_disable(mii_disable)
  );

  function automatic logic [4:0] exp_out();
    logic [4:0] ind;
    ind[0] = m_cnt[0] != 0;
    ind[1] = st_col;
    ind[2] = st_link;
    ind[3] = m_cnt[3] != 0;
    ind[4] = m_cnt[4] != 0;
    return m_oe ? (m_strap ^ ind) : 5'b0;
  endfunction

  task automatic model_edge();
    logic [4:0] st;
    st = {st_rxd, st_txd, st_link, st_col, st_act};
    if (!(por_n && hw_rst_n)) begin
      m_oe = 1'b0; m_strap = 5'b0;
    end else if (!m_oe) begin
      m_oe = 1'b1; m_strap = pin_in;
    end
    for (int i = 0; i < 5; i++) begin
      if (!(por_n && hw_rst_n) || sw_rst) m_cnt[i] = 0;
      else if (st[i]) m_cnt[i] = STRETCH;
      else if (m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
    end
  endtask

  task automatic chk(string req, string what, logic [4:0] act, logic [4:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic tick(string req);
    @(posedge clk);
    model_edge();
    #1;
    chk(req, "pin_oe", pin_oe, {5{m_oe}});
    chk(req, "phy_addr", phy_addr, m_strap);
    chk(req, "pin_out", pin_out, exp_out());
    chk("R9", "mii_disable", {4'b0, mii_disable}, {4'b0, m_strap == 5'b0});
  endtask

  task automatic set_st(logic a, logic c, logic l, logic t, logic r);
    st_act = a; st_col = c; st_link = l; st_txd = t; st_rxd = r;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    // R1: held in reset, pads wiggle, outputs stay off
    for (int k = 0; k < 4; k++) begin
      pin_in = 5'($urandom);
      set_st(1, 1, 1, 1, 1);
      tick("R1");
    end
    set_st(0, 0, 0, 0, 0);
    hw_rst_n = 1'b1;
    tick("R1");
    // R2: release reset with a strap pattern
    por_n = 1'b1; pin_in = 5'b10110;
    tick("R2");
    // R3: straps ignored afterwards
    pin_in = 5'b01001; tick("R3");
    pin_in = 5'b00000; tick("R3");
    // R5: idle
    tick("R5");
    // R6: level statuses
    set_st(0, 1, 0, 0, 0); tick("R6");
    set_st(0, 0, 1, 0, 0); tick("R6");
    set_st(0, 1, 1, 0, 0); tick("R6");
    set_st(0, 0, 0, 0, 0); tick("R6");
    // R7: single-cycle pulses and stretch window
    set_st(1, 0, 0, 0, 0); tick("R7");
    set_st(0, 0, 0, 0, 0);
    for (int k = 0; k < STRETCH + 1; k++) tick("R7");
    set_st(0, 0, 0, 1, 1); tick("R7");
    set_st(0, 0, 0, 0, 0); tick("R7"); tick("R7");
    set_st(0, 0, 0, 1, 0); tick("R7");
    set_st(0, 0, 0, 0, 0);
    for (int k = 0; k < STRETCH + 1; k++) tick("R7");
    // R8 / R4: software reset clears stretch, keeps straps
    set_st(1, 0, 0, 1, 1); tick("R8");
    set_st(1, 0, 0, 0, 0); sw_rst = 1'b1; pin_in = 5'b11111; tick("R4");
    sw_rst = 1'b0; set_st(0, 0, 0, 0, 0); tick("R8");
    // R9: zero address
    por_n = 1'b0; tick("R1");
    por_n = 1'b1; pin_in = 5'b00000; tick("R9");
    pin_in = 5'b00100; tick("R9");
    // R2: all-ones strap via hardware reset
    hw_rst_n = 1'b0; tick("R1");
    hw_rst_n = 1'b1; pin_in = 5'b11111; tick("R2");
    set_st(1, 1, 1, 1, 1); tick("R7");
    set_st(0, 0, 0, 0, 0); tick("R7");
    // random phase
    for (int k = 0; k < 3000; k++) begin
      por_n    = ($urandom_range(0, 199) != 0);
      hw_rst_n = ($urandom_range(0, 199) != 0);
      sw_rst   = ($urandom_range(0, 29) == 0);
      pin_in   = 5'($urandom);
      set_st($urandom_range(0, 7) == 0, $urandom_range(0, 3) == 0,
             $urandom_range(0, 1) == 0, $urandom_range(0, 7) == 0,
             $urandom_range(0, 7) == 0);
      tick(sw_rst ? "R8" : "R7");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule